// File: doc/BRIEF.md
# Cascadable dual 8-bit timer

Two 8-bit up-counters share one free-running prescaler and one system clock. Each channel has a control byte, two compare bytes, a counter byte, a status byte holding three event flags (compare A, compare B, overflow) and an external-edge selector. A channel's counter advances on one source at a time: a falling edge of a prescaler tap, a pulse from the other channel, or an edge of the external clock pin. It can be cleared by its own compare events or by a rising edge of the external reset pin.

The channels can be chained. Channel 0 can count channel 1 overflows, which makes a 16-bit counter with channel 0 as the high byte. Channel 1 can count channel 0 compare-A events. If both channels are set to count each other, the block detects this and holds both counters. Software reaches all registers through a simple byte-wide bus. Reads are combinational on the address, and a read strobe marks a status read.

Top module: `dual_timer`

## Requirements
- R1: After reset every register of both channels reads 0 and all six interrupt outputs are low. The address is {channel, offset}, with channel in addr_i[3]. Offsets: 0 control, 1 status, 2 compare A, 3 compare B, 4 counter, 5 external-edge selector.
- R2: With clock select (control bits 2:0) at 000, edge selector 00 and clear mode 00, the counter holds its value.
- R3: On channel 0, clock select codes 001..110 advance the counter by one per falling edge of the prescaler divided by 8, 2, 64, 32, 1024 and 256 respectively. A window of k·N cycles gives exactly k counts.
- R4: On channel 1, codes 001..110 divide by 8, 2, 64, 128, 1024 and 2048 respectively.
- R5: Code 111 on channel 0 counts each channel 1 overflow. Code 111 on channel 1 counts each channel 0 compare-A event.
- R6: If both channels select code 111, neither counter advances on the chain events.
- R7: Clear mode (control bits 4:3) 01 clears the counter on a compare-A event and 10 on a compare-B event. A clear wins over an increment in the same cycle.
- R8: Clear mode 11 clears the counter on a rising edge of ext_rst_i, after a two-flop synchronizer. A falling edge of ext_rst_i does not clear the counter.
- R9: A nonzero edge selector (offset 5, bits 1:0) makes the counter advance on ext_clk_i instead of the clock select: 01 on rising edges, 10 on falling edges, 11 on both.
- R10: Status bit 6 is set when the counter becomes equal to compare A, bit 7 likewise for compare B, and bit 5 when the counter wraps from 0xFF to 0x00.
- R11: A status flag clears only when software writes 0 to it after a status read that returned it as 1. Writing 1, or writing 0 without a prior read, leaves the flag set.
- R12: Each interrupt output is high only while its flag and its enable bit are both 1. The enable bits are control bit 7 for compare B, bit 6 for compare A and bit 5 for overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms flag clearing) |
| addr_i | input | 4 | Register address {channel, offset} |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| ext_clk_i | input | 1 | External count clock pin |
| ext_rst_i | input | 1 | External counter reset pin |
| irq_cmpa_o | output | 2 | Compare-A interrupt, one per channel |
| irq_cmpb_o | output | 2 | Compare-B interrupt, one per channel |
| irq_ovf_o | output | 2 | Overflow interrupt, one per channel |

## Verification
The bench runs every prescaler code on both channels over exact multiples of its divisor. A tap wired to the wrong bit, or a count made on both edges, then gives a wrong count. It chains the channels in both directions and then sets up the mutual chain, in which a missing hold lets a compare event still advance channel 1. The clear and edge tests use compare clears, a falling ext_rst_i, and all three external edge modes. Randomised compare writes, and the read-then-write flag protocol, catch flags that clear on a bare write or that fail to set.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_CMPA = 3'd2;
  localparam logic [2:0] REG_CMPB = 3'd3;
  localparam logic [2:0] REG_CNT  = 3'd4;
  localparam logic [2:0] REG_EXT  = 3'd5;

  localparam logic [2:0] CKS_OFF   = 3'd0;
  localparam logic [2:0] CKS_CHAIN = 3'd7;

  typedef enum logic [1:0] {CLR_NONE, CLR_CMPA, CLR_CMPB, CLR_EXT} clr_mode_e;
  typedef enum logic [1:0] {EXT_OFF, EXT_RISE, EXT_FALL, EXT_BOTH} ext_mode_e;

  // prescaler bit whose falling edge serves a clock select code
  function automatic int tap_index(input int ch, input logic [2:0] code);
    int idx;
    case (code)
      3'd1:    idx = 2;
      3'd2:    idx = 0;
      3'd3:    idx = 5;
      3'd4:    idx = (ch == 0) ? 4 : 6;
      3'd5:    idx = 9;
      3'd6:    idx = (ch == 0) ? 7 : 10;
      default: idx = 0;
    endcase
    return idx;
  endfunction
endpackage

// File: rtl/dual_timer_prescaler.sv
module dual_timer_prescaler #(
  parameter int PRE_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PRE_W-1:0] fall_o
);
  logic [PRE_W-1:0] cnt_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      prev_q <= cnt_q;
    end
  end

  assign fall_o = prev_q & ~cnt_q;
endmodule

// File: rtl/dual_timer_edge_sync.sv
module dual_timer_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], in_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/dual_timer_channel.sv
module dual_timer_channel
  import dual_timer_pkg::*;
#(
  parameter int CH_ID = 0,
  parameter int CNT_W = 8,
  parameter int PRE_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [2:0]       reg_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [PRE_W-1:0] tick_i,
  input  logic             ext_rise_i,
  input  logic             ext_fall_i,
  input  logic             ext_rst_i,
  input  logic             chain_evt_i,
  input  logic             hold_i,
  output logic             chain_sel_o,
  output logic             ovf_evt_o,
  output logic             cmpa_evt_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       ctrl_o,
  output logic [1:0]       ext_o,
  output logic [2:0]       flags_o,
  output logic [2:0]       irq_o
);
  localparam int TAP_W = $clog2(PRE_W);

  logic [7:0]       ctrl_q;
  logic [CNT_W-1:0] cmpa_q, cmpb_q, cnt_q, cnt_d;
  logic [2:0]       flags_q, armed_q, evt, flag_clr;
  ext_mode_e        ext_q;
  logic             ma_q, mb_q;
  logic             match_a, match_b, cmpa_evt, cmpb_evt;
  logic             src_evt, clr_hit, wr_cnt, wr_stat, rd_stat;
  logic [TAP_W-1:0] tap_sel;
  logic [2:0]       cks;
  clr_mode_e        clr_mode;

  assign cks      = ctrl_q[2:0];
  assign clr_mode = clr_mode_e'(ctrl_q[4:3]);
  assign tap_sel  = TAP_W'(tap_index(CH_ID, cks));

  assign wr_cnt  = wr_i && (reg_i == REG_CNT);
  assign wr_stat = wr_i && (reg_i == REG_STAT);
  assign rd_stat = rd_i && (reg_i == REG_STAT);

  always_comb begin
    src_evt = 1'b0;
    unique case (ext_q)
      EXT_RISE: src_evt = ext_rise_i;
      EXT_FALL: src_evt = ext_fall_i;
      EXT_BOTH: src_evt = ext_rise_i | ext_fall_i;
      default: begin
        if (cks == CKS_CHAIN)    src_evt = chain_evt_i & ~hold_i;
        else if (cks != CKS_OFF) src_evt = tick_i[tap_sel];
      end
    endcase
  end

  assign chain_sel_o = (ext_q == EXT_OFF) && (cks == CKS_CHAIN);

  // compare events fire once when equality is reached
  assign match_a  = (cnt_q == cmpa_q);
  assign match_b  = (cnt_q == cmpb_q);
  assign cmpa_evt = match_a & ~ma_q;
  assign cmpb_evt = match_b & ~mb_q;

  always_comb begin
    unique case (clr_mode)
      CLR_CMPA: clr_hit = cmpa_evt;
      CLR_CMPB: clr_hit = cmpb_evt;
      CLR_EXT:  clr_hit = ext_rst_i;
      default:  clr_hit = 1'b0;
    endcase
  end

  assign ovf_evt_o = src_evt & ~clr_hit & ~wr_cnt & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt)       cnt_d = wdata_i;
    else if (clr_hit) cnt_d = '0;
    else if (src_evt) cnt_d = cnt_q + 1'b1;
  end

  assign evt      = {cmpb_evt, cmpa_evt, ovf_evt_o};
  assign flag_clr = {3{wr_stat}} & ~wdata_i[7:5] & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      cmpa_q  <= '0;
      cmpb_q  <= '0;
      cnt_q   <= '0;
      ext_q   <= EXT_OFF;
      flags_q <= '0;
      armed_q <= '0;
      ma_q    <= 1'b1;
      mb_q    <= 1'b1;
    end else begin
      if (wr_i && reg_i == REG_CTRL) ctrl_q <= wdata_i[7:0];
      if (wr_i && reg_i == REG_CMPA) cmpa_q <= wdata_i;
      if (wr_i && reg_i == REG_CMPB) cmpb_q <= wdata_i;
      if (wr_i && reg_i == REG_EXT)  ext_q  <= ext_mode_e'(wdata_i[1:0]);
      cnt_q   <= cnt_d;
      flags_q <= evt | (flags_q & ~flag_clr);
      armed_q <= (armed_q & ~flag_clr) | ({3{rd_stat}} & flags_q);
      ma_q    <= match_a;
      mb_q    <= match_b;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (reg_i)
      REG_CTRL: rdata_o = CNT_W'(ctrl_q);
      REG_STAT: rdata_o = CNT_W'({flags_q, 5'b0});
      REG_CMPA: rdata_o = cmpa_q;
      REG_CMPB: rdata_o = cmpb_q;
      REG_CNT:  rdata_o = cnt_q;
      REG_EXT:  rdata_o = CNT_W'(ext_q);
      default:  rdata_o = '0;
    endcase
  end

  assign cmpa_evt_o = cmpa_evt;
  assign cnt_o      = cnt_q;
  assign ctrl_o     = ctrl_q;
  assign ext_o      = ext_q;
  assign flags_o    = flags_q;
  assign irq_o      = flags_q & ctrl_q[7:5];
endmodule

// File: rtl/dual_timer.sv
module dual_timer #(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  input  logic [3:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             ext_clk_i,
  input  logic             ext_rst_i,
  output logic [1:0]       irq_cmpa_o,
  output logic [1:0]       irq_cmpb_o,
  output logic [1:0]       irq_ovf_o
);
  localparam int N_PINS = 2;

  logic [PRE_W-1:0]  tick;
  logic [N_PINS-1:0] pin_in, pin_rise, pin_fall;

  dual_timer_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_o(tick)
  );

  // pin 0: external clock, pin 1: external reset
  assign pin_in = {ext_rst_i, ext_clk_i};

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    dual_timer_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .in_i(pin_in[p]),
      .rise_o(pin_rise[p]), .fall_o(pin_fall[p])
    );
  end

  logic             sel0, sel1, hold;
  logic             ovf_evt0, ovf_evt1, cmpa_evt0, cmpa_evt1;
  logic [CNT_W-1:0] rd0, rd1, cnt0_w, cnt1_w;
  logic [7:0]       ctrl0_w, ctrl1_w;
  logic [1:0]       ext0_w, ext1_w;
  logic [2:0]       flags0_w, flags1_w, irq0, irq1;

  // mutual chaining would starve both counters
  assign hold = sel0 & sel1;

  dual_timer_channel #(.CH_ID(0), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch0 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_en_i & ~addr_i[3]), .rd_i(rd_en_i & ~addr_i[3]),
    .reg_i(addr_i[2:0]), .wdata_i(wdata_i), .rdata_o(rd0),
    .tick_i(tick), .ext_rise_i(pin_rise[0]), .ext_fall_i(pin_fall[0]),
    .ext_rst_i(pin_rise[1]), .chain_evt_i(ovf_evt1), .hold_i(hold),
    .chain_sel_o(sel0), .ovf_evt_o(ovf_evt0), .cmpa_evt_o(cmpa_evt0),
    .cnt_o(cnt0_w), .ctrl_o(ctrl0_w), .ext_o(ext0_w), .flags_o(flags0_w),
    .irq_o(irq0)
  );

  dual_timer_channel #(.CH_ID(1), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch1 (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_en_i & addr_i[3]), .rd_i(rd_en_i & addr_i[3]),
    .reg_i(addr_i[2:0]), .wdata_i(wdata_i), .rdata_o(rd1),
    .tick_i(tick), .ext_rise_i(pin_rise[0]), .ext_fall_i(pin_fall[0]),
    .ext_rst_i(pin_rise[1]), .chain_evt_i(cmpa_evt0), .hold_i(hold),
    .chain_sel_o(sel1), .ovf_evt_o(ovf_evt1), .cmpa_evt_o(cmpa_evt1),
    .cnt_o(cnt1_w), .ctrl_o(ctrl1_w), .ext_o(ext1_w), .flags_o(flags1_w),
    .irq_o(irq1)
  );

  assign rdata_o    = addr_i[3] ? rd1 : rd0;
  assign irq_cmpb_o = {irq1[2], irq0[2]};
  assign irq_cmpa_o = {irq1[1], irq0[1]};
  assign irq_ovf_o  = {irq1[0], irq0[0]};
endmodule

// File: rtl/dual_timer_checker.sv
module dual_timer_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [3:0]       addr_i,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [7:0]       ctrl0,
  input logic [7:0]       ctrl1,
  input logic [1:0]       ext0,
  input logic [1:0]       ext1,
  input logic [2:0]       flags0,
  input logic [2:0]       flags1,
  input logic             ovf_evt0,
  input logic             ovf_evt1,
  input logic             cmpa_evt1,
  input logic [1:0]       irq_cmpa_o
);
  logic cnt_wr;
  assign cnt_wr = wr_en_i && (addr_i[2:0] == 3'd4);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl0[4:0] == 5'd0 && ext0 == 2'd0 && !cnt_wr) |=> cnt0 == $past(cnt0));

  p_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt0) |-> (cnt0 == $past(cnt0) + 1'b1 || cnt0 == '0 || $past(wr_en_i)));

  p_deadlock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl0[4:0] == 5'd7 && ctrl1[4:0] == 5'd7 && ext0 == 2'd0 && ext1 == 2'd0 && !cnt_wr)
    |=> ($stable(cnt0) && $stable(cnt1)));

  p_ovf_wrap0_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt0 |=> (cnt0 == '0 && flags0[0]));

  p_ovf_wrap1_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt1 |=> (cnt1 == '0 && flags1[0]));

  p_cmpa_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpa_evt1 |=> flags1[1]);

  p_flag_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags0[1]) |-> ($past(wr_en_i) && $past(addr_i) == 4'h1));

  p_irq_en_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_cmpa_o[0] |-> (ctrl0[6] && flags0[1]));
endmodule

bind dual_timer dual_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .cnt0(cnt0_w), .cnt1(cnt1_w), .ctrl0(ctrl0_w), .ctrl1(ctrl1_w),
  .ext0(ext0_w), .ext1(ext1_w), .flags0(flags0_w), .flags1(flags1_w),
  .ovf_evt0(ovf_evt0), .ovf_evt1(ovf_evt1), .cmpa_evt1(cmpa_evt1),
  .irq_cmpa_o(irq_cmpa_o)
);

// File: tb/dual_timer_test.sv
module dual_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ext_clk = 1'b0, ext_rst = 1'b0;
  logic [1:0] irq_a, irq_b, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  dual_timer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ext_clk_i(ext_clk), .ext_rst_i(ext_rst),
    .irq_cmpa_o(irq_a), .irq_cmpb_o(irq_b), .irq_ovf_o(irq_o)
  );

  always #10 clk = ~clk;

  function automatic int div_of(input int ch, input int code);
    case (code)
      1: return 8;
      2: return 2;
      3: return 64;
      4: return (ch == 0) ? 32 : 128;
      5: return 1024;
      default: return (ch == 0) ? 256 : 2048;
    endcase
  endfunction

  function automatic bit exp_cmp_flag(input logic [7:0] c, input logic [7:0] a);
    return c == a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle_ext(input int n);
    for (int i = 0; i < n; i++) begin
      ext_clk = 1'b1; wait_cyc(8);
      ext_clk = 1'b0; wait_cyc(8);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4711));
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    for (int ch = 0; ch < 2; ch++)
      for (int r = 0; r < 6; r++) begin
        peek(4'((ch << 3) | r), d);
        chk(d == 8'h00, "R1 reset register", d, 0);
      end
    chk({irq_a, irq_b, irq_o} == 6'b0, "R1 irq idle", {irq_a, irq_b, irq_o}, 0);

    // R2 disabled hold
    wr(4'h4, 8'h20);
    wait_cyc(100);
    peek(4'h4, d);
    chk(d == 8'h20, "R2 select 000 holds", d, 8'h20);

    // R3 / R4 prescaler rates
    for (int ch = 0; ch < 2; ch++)
      for (int code = 1; code <= 6; code++) begin
        int n, k;
        n = div_of(ch, code);
        k = (n <= 64) ? 40 : 4;
        wr(4'(ch << 3), 8'h00);
        wr(4'((ch << 3) | 4), 8'h00);
        wr(4'(ch << 3), 8'(code));
        wait_cyc(n * k);
        peek(4'((ch << 3) | 4), d);
        if (ch == 0) chk(d == 8'(k), "R3 ch0 tap rate", d, k);
        else         chk(d == 8'(k), "R4 ch1 tap rate", d, k);
      end
    wr(4'h0, 8'h00);
    wr(4'h8, 8'h00);

    // R7 clear on compare A and compare B
    begin
      bit bad, seen;
      wr(4'h2, 8'd5); wr(4'h4, 8'h00); wr(4'h0, 8'h0A);
      bad = 0; seen = 0;
      for (int i = 0; i < 200; i++) begin
        wait_cyc(1); peek(4'h4, d);
        if (d > 8'd5) bad = 1;
        if (d == 8'd5) seen = 1;
      end
      chk(!bad && seen, "R7 clear on compare A", d, 5);
      wr(4'h0, 8'h00);
      wr(4'h2, 8'hF0); wr(4'h3, 8'd9); wr(4'h4, 8'h00); wr(4'h0, 8'h12);
      bad = 0; seen = 0;
      for (int i = 0; i < 200; i++) begin
        wait_cyc(1); peek(4'h4, d);
        if (d > 8'd9) bad = 1;
        if (d == 8'd9) seen = 1;
      end
      chk(!bad && seen, "R7 clear on compare B", d, 9);
      wr(4'h0, 8'h00);
    end

    // R8 external reset edge
    wr(4'h0, 8'h18); wr(4'h4, 8'h55);
    wait_cyc(10); peek(4'h4, d);
    chk(d == 8'h55, "R8 no clear while low", d, 8'h55);
    ext_rst = 1'b1; wait_cyc(8); peek(4'h4, d);
    chk(d == 8'h00, "R8 rising edge clears", d, 0);
    wr(4'h4, 8'h33);
    ext_rst = 1'b0; wait_cyc(8); peek(4'h4, d);
    chk(d == 8'h33, "R8 falling edge ignored", d, 8'h33);
    wr(4'h0, 8'h00);

    // R9 external clock edges
    wr(4'h5, 8'h01); wr(4'h4, 8'h00); toggle_ext(5); peek(4'h4, d);
    chk(d == 8'd5, "R9 rising edges", d, 5);
    wr(4'h5, 8'h02); wr(4'h4, 8'h00); toggle_ext(5); peek(4'h4, d);
    chk(d == 8'd5, "R9 falling edges", d, 5);
    wr(4'h5, 8'h03); wr(4'h4, 8'h00); toggle_ext(5); peek(4'h4, d);
    chk(d == 8'd10, "R9 both edges", d, 10);
    wr(4'h5, 8'h00);

    // R5 16-bit chain: ch0 counts ch1 overflows
    wr(4'h4, 8'h00); wr(4'hC, 8'h00); wr(4'hA, 8'h80);
    rd(4'h9); wr(4'h9, 8'h00);
    wr(4'h0, 8'h07); wr(4'h8, 8'h02);
    wait_cyc(1536);
    peek(4'hC, d); chk(d == 8'h00, "R5 chain low byte", d, 0);
    peek(4'h4, d); chk(d == 8'h03, "R5 chain high byte", d, 3);
    peek(4'h9, d); chk(d[5], "R10 ch1 overflow flag", d, 8'h20);

    // R5 ch1 counts ch0 compare-A events
    wr(4'h8, 8'h00); wr(4'h0, 8'h00);
    wr(4'h2, 8'd3); wr(4'h4, 8'h00); wr(4'hC, 8'h00);
    wr(4'h8, 8'h07);
    wr(4'h4, 8'd3); wr(4'h4, 8'd4); wr(4'h4, 8'd3);
    wait_cyc(2);
    peek(4'hC, d); chk(d == 8'd2, "R5 ch1 counts compare A", d, 2);
    peek(4'h1, d); chk(d[6], "R10 ch0 compare-A flag", d, 8'h40);

    // R6 mutual chain holds
    wr(4'h0, 8'h07);
    wr(4'h4, 8'h00); wr(4'h4, 8'd3);
    wait_cyc(4);
    peek(4'hC, d); chk(d == 8'd2, "R6 mutual chain holds", d, 2);

    // R11 flag clear protocol
    wr(4'h1, 8'h00); peek(4'h1, d);
    chk(d[6], "R11 write 0 without read keeps", d, 8'h40);
    rd(4'h1);
    wr(4'h1, 8'hFF); peek(4'h1, d);
    chk(d[6], "R11 write 1 keeps", d, 8'h40);
    wr(4'h1, 8'h00); peek(4'h1, d);
    chk(!d[6], "R11 read then write 0 clears", d, 0);

    // R12 interrupt gating
    wr(4'h0, 8'h00);
    wr(4'h4, 8'h00); wr(4'h4, 8'd3);
    wait_cyc(2);
    chk(irq_a == 2'b00, "R12 irq masked", irq_a, 0);
    wr(4'h0, 8'h40); wait_cyc(1);
    chk(irq_a == 2'b01, "R12 irq enabled", irq_a, 1);
    wr(4'h0, 8'h00); wait_cyc(1);
    chk(irq_a == 2'b00, "R12 irq disabled", irq_a, 0);

    // R10 random compare writes
    for (int i = 0; i < 24; i++) begin
      logic [7:0] a, c;
      a = 8'($urandom);
      c = ($urandom % 2 == 0) ? a : 8'($urandom);
      wr(4'h2, a);
      wr(4'h4, a ^ 8'h80);
      rd(4'h1); wr(4'h1, 8'h00);
      wr(4'h4, c);
      wait_cyc(2);
      peek(4'h1, d);
      chk(d[6] == exp_cmp_flag(c, a), "R10 compare-A flag", d[6], exp_cmp_flag(c, a));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule